// File: doc/BRIEF.md
# Bit-Oriented Message Receiver

This block monitors the serial data-link channel of an extended-superframe T1 stream. It looks for 16-bit bit-oriented codewords. One data-link bit arrives per strobe. The receiver keeps a sliding window of the latest sixteen bits. A window is a valid codeword when it holds a flag of eight ones followed by a message byte whose first and last bits are zero. When it sees one, it stores the message byte and raises a valid flag.

The first valid codeword locks the receiver to 16-bit group boundaries. From then on, every sixteenth strobe it judges the group just completed:
- A good group refreshes the stored byte, and the flag stays high.
- A bad group drops the flag but leaves the stored byte in place. The receiver then returns to a bit-by-bit hunt for the next codeword.

Clock cycles without a strobe do nothing.

Top module: `bom_receiver`

## Requirements
- R1: While reset is active, and on the first cycle after it, the stored message is 0x00 and the valid flag is low.
- R2: While hunting, the strobe that completes eight ones followed by a byte with first and last bits zero raises the valid flag on the clock edge of that strobe and stores that byte. One strobe earlier, nothing has changed.
- R3: The first message bit received after the flag lands in the stored byte's bit 7, and the last one lands in bit 0.
- R4: While hunting, eight ones followed by a byte whose first bit or last bit is one are not accepted, and the flag stays low.
- R5: A run of only seven ones ahead of a well-formed byte is not accepted.
- R6: Once locked, each group of sixteen strobes is judged at its sixteenth strobe only. A good group replaces the stored byte and keeps the flag high, and the stored byte changes at no other strobe.
- R7: Once locked, a bad group clears the flag at its sixteenth strobe and leaves the stored byte unchanged.
- R8: After reset or after a bad group, the receiver searches at every bit position and accepts a codeword that starts at any offset.
- R9: Cycles with the strobe low change neither output nor the group position, whatever the data bit holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dl_bit | input | 1 | Serial data-link bit, sampled when `bit_stb` is high |
| bit_stb | input | 1 | Bit-slot strobe, one cycle per data-link bit |
| rx_msg | output | MSG_W (8) | Last accepted message byte |
| rx_valid | output | 1 | High while the most recent judged codeword was valid |

## Verification
The bench goes after the edges of the pattern:
- A byte with a one in its first or last position after a full flag. A matcher that checks only the flag would accept it.
- A flag one bit short. An off-by-one flag width would accept it.
- Reversed bit order. The asymmetric byte 0x0A would come out as 0x50.
- A group that goes bad after lock. A design that clears the byte along with the flag would lose the stored message.

Idle cycles with toggling data are placed inside a locked group. A receiver that counts clocks instead of strobes would then judge the group at the wrong place. Random streams with injected, damaged and shifted codewords are compared bit by bit with a reference model. These streams catch misplaced re-hunt and lock behaviour.

// File: rtl/bomrx_pkg.sv
// Package: shared types for the bit-oriented message receiver.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package bomrx_pkg;
    // Receiver alignment state: hunting bit by bit, or locked to groups.
    typedef enum logic {
        RX_HUNT = 1'b0,
        RX_LOCK = 1'b1
    } bomrx_state_e;
endpackage

// File: rtl/bomrx_shift.sv
// Module: bomrx_shift
// Holds the most recent WIN_W data-link bits, newest bit in bit 0.
// Assumes: shift_en is a single-cycle strobe per incoming bit.
module bomrx_shift #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIN_W-1:0] win
);
    // Shift the new bit in at the bottom on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win <= '0;
        else if (shift_en)
            win <= {win[WIN_W-2:0], din};
    end
endmodule

// File: rtl/bomrx_match.sv
// Module: bomrx_match
// Combinational test of a candidate window against the codeword form:
// FLAG_W ones, then a MSG_W-bit byte with its first and last bits zero.
// Assumes: the oldest bit sits in the window's MSB.
module bomrx_match #(
    parameter int FLAG_W = 8,
    parameter int MSG_W  = 8,
    localparam int CW    = FLAG_W + MSG_W
) (
    input  logic [CW-1:0] cand,
    output logic          hit
);
    logic [FLAG_W-1:0] flag_ok;

    // Per-bit flag check, one cell per flag position.
    for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
        assign flag_ok[g] = cand[MSG_W + g];
    end

    // Whole-pattern decision: all flag ones, both message end bits zero.
    always_comb begin
        hit = (&flag_ok) && !cand[MSG_W-1] && !cand[0];
    end
endmodule

// File: rtl/bomrx_track.sv
// Module: bomrx_track
// Alignment tracker: captures the message on the first hit, then judges
// every CW-th strobe, refreshing or dropping lock as the group dictates.
// Assumes: hit and cand_msg describe the window including the current bit.
module bomrx_track
    import bomrx_pkg::*;
#(
    parameter int FLAG_W = 8,
    parameter int MSG_W  = 8,
    localparam int CW    = FLAG_W + MSG_W,
    localparam int CNT_W = $clog2(CW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             hit,
    input  logic [MSG_W-1:0] cand_msg,
    output logic [MSG_W-1:0] msg,
    output logic             valid
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CW - 1);

    bomrx_state_e     state;
    logic [CNT_W-1:0] pos;

    // Hunt or group-judge on each strobe; hold everything between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_HUNT;
            pos   <= '0;
            msg   <= '0;
        end else if (stb) begin
            if (state == RX_HUNT) begin
                if (hit) begin
                    msg   <= cand_msg;
                    state <= RX_LOCK;
                    pos   <= '0;
                end
            end else if (pos == LAST_POS) begin
                pos <= '0;
                if (hit)
                    msg <= cand_msg;
                else
                    state <= RX_HUNT;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    // The flag reflects the verdict on the most recently judged codeword.
    assign valid = (state == RX_LOCK);

    // R6: inside a locked group the stored byte and flag only move at the end.
    a_r6_group_end_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_LOCK && stb && pos != LAST_POS) |=> ($stable(msg) && valid));

    // R7: a dropped flag never disturbs the stored byte.
    a_r7_keep_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> $stable(msg));
endmodule

// File: rtl/bom_receiver.sv
// Module: bom_receiver (top)
// Bit-oriented message receiver for the serial data link: window, matcher
// and alignment tracker. Outputs the last good byte and a valid flag.
// Assumes: bit_stb is high for exactly one cycle per data-link bit.
module bom_receiver #(
    parameter int FLAG_W = 8,
    parameter int MSG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dl_bit,
    input  logic             bit_stb,
    output logic [MSG_W-1:0] rx_msg,
    output logic             rx_valid
);
    localparam int CW = FLAG_W + MSG_W;

    logic [CW-1:0] win;
    logic [CW-1:0] cand;
    logic          hit;

    bomrx_shift #(.WIN_W(CW)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_stb),
        .din      (dl_bit),
        .win      (win)
    );

    // Candidate window as it stands once the current bit is included.
    always_comb begin
        cand = {win[CW-2:0], dl_bit};
    end

    bomrx_match #(.FLAG_W(FLAG_W), .MSG_W(MSG_W)) match_i (
        .cand (cand),
        .hit  (hit)
    );

    bomrx_track #(.FLAG_W(FLAG_W), .MSG_W(MSG_W)) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (bit_stb),
        .hit      (hit),
        .cand_msg (cand[MSG_W-1:0]),
        .msg      (rx_msg),
        .valid    (rx_valid)
    );

    // R1: the first cycle out of reset shows a cleared byte and low flag.
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (rx_msg == '0 && !rx_valid));

    // R9: a cycle without a strobe leaves both outputs untouched.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_stb |=> ($stable(rx_msg) && $stable(rx_valid)));

    // R2: any newly stored byte has zero end bits and comes with the flag up.
    a_r2_stored_form: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && !$stable(rx_msg)) |->
        (!rx_msg[MSG_W-1] && !rx_msg[0] && rx_valid));
endmodule

// File: tb/bom_receiver_tb_top.sv
module bom_receiver_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dl_bit = 1'b0;
    logic       bit_stb = 1'b0;
    logic [7:0] rx_msg;
    logic       rx_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit use_model = 0;

    // Reference model state
    logic [15:0] m_win;
    bit          m_lock;
    int          m_cnt;
    logic [7:0]  m_msg;

    always #4 clk = ~clk;

    bom_receiver dut_i (
        .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .bit_stb(bit_stb),
        .rx_msg(rx_msg), .rx_valid(rx_valid)
    );

    function automatic bit is_code(logic [15:0] w);
        return (w[15:8] == 8'hFF) && !w[7] && !w[0];
    endfunction

    task automatic model_step(input logic b);
        logic [15:0] nw;
        nw = {m_win[14:0], b};
        if (!m_lock) begin
            if (is_code(nw)) begin
                m_msg = nw[7:0]; m_lock = 1; m_cnt = 0;
            end
        end else if (m_cnt == 15) begin
            m_cnt = 0;
            if (is_code(nw)) m_msg = nw[7:0];
            else m_lock = 0;
        end else begin
            m_cnt++;
        end
        m_win = nw;
    endtask

    task automatic chk(input string tag, input logic [8:0] exp);
        n_tests++;
        if ({rx_valid, rx_msg} !== exp) begin
            n_fail++;
            $display("FAIL %s: actual valid=%0b msg=%02h expected valid=%0b msg=%02h",
                     tag, rx_valid, rx_msg, exp[8], exp[7:0]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bit_stb = 0; dl_bit = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        m_win = '0; m_lock = 0; m_cnt = 0; m_msg = '0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        dl_bit = b; bit_stb = 1;
        @(negedge clk);
        bit_stb = 0;
        model_step(b);
        if (use_model) chk("R2/R6/R7/R8 model", {m_lock, m_msg});
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dl_bit = 1'($urandom);
            bit_stb = 0;
        end
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        chk("R1 reset", 9'h000);

        // R2: detection exactly on the 16th bit
        send_bits(8'hFF, 8);
        send_bits(8'h3C, 7);
        chk("R2 before last bit", 9'h000);
        send_bit(1'b0);
        chk("R2 detect", {1'b1, 8'h3C});

        // R3 / R6: aligned next group with an asymmetric byte
        send_bits(8'hFF, 8);
        send_bits(8'h0A, 8);
        chk("R3 bit order / R6 refresh", {1'b1, 8'h0A});

        // R9: idle cycles mid-group do not move the group position
        send_bits(8'hFF, 8);
        send_bits(8'h24, 4);
        idle(20);
        chk("R9 idle hold", {1'b1, 8'h0A});
        for (int i = 3; i >= 0; i--) send_bit(1'(8'h24 >> i));
        chk("R9 group position kept", {1'b1, 8'h24});

        // R7: bad group clears flag, keeps byte
        send_bits(8'hFF, 8);
        send_bits(8'h01, 8);
        chk("R7 invalid group", {1'b0, 8'h24});

        // R8: re-hunt at an arbitrary offset after a bad group
        send_bits(8'h00, 5);
        send_bits(8'hFF, 8);
        send_bits(8'h42, 8);
        chk("R8 re-hunt", {1'b1, 8'h42});

        // R4: first message bit one
        do_reset();
        send_bits(8'h00, 8);
        send_bits(8'hFF, 8);
        send_bits(8'h80, 8);
        chk("R4 first bit one", 9'h000);

        // R4: last message bit one
        do_reset();
        send_bits(8'h00, 8);
        send_bits(8'hFF, 8);
        send_bits(8'h01, 8);
        chk("R4 last bit one", 9'h000);

        // R5: seven-ones flag
        do_reset();
        send_bits(8'h00, 8);
        send_bits(8'h7F, 8);
        send_bits(8'h3C, 8);
        chk("R5 short flag", 9'h000);

        // R8: offset detection from reset, extreme content
        do_reset();
        send_bits(8'h00, 3);
        send_bits(8'hFF, 8);
        send_bits(8'h7E, 8);
        chk("R8 offset detect", {1'b1, 8'h7E});

        // Random streams against the model
        do_reset();
        use_model = 1;
        for (int k = 0; k < 1500; k++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 3) begin
                send_bits(8'hFF, 8);
                send_bits({1'b0, 6'($urandom), 1'b0}, 8);
            end else if (sel < 4) begin
                send_bits(8'hFF, 8);
                send_bits(8'($urandom) | 8'h01, 8);
            end else if (sel < 5) begin
                idle($urandom_range(1, 4));
            end else begin
                send_bit(1'($urandom));
            end
        end
        use_model = 0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule